// File: doc/BRIEF.md
# Multi-mode funnel shifter

This block shifts or rotates an N-bit operand (N = 32 by default) by an amount k in the range 0 to N-1. It handles logical, arithmetic and rotate operations in both directions with one mux structure. A small control unit turns the direction and the operation kind into a few strobes. A source builder uses those strobes to form a (2N-1)-bit funnel word. A logarithmic chain of 2:1 multiplexer stages then cuts an N-bit window out of that word. Each stage is steered directly by one bit of the offset, so k is never decoded.

Right operations keep the operand in the low N bits of the funnel word and select at offset k. Left operations keep the operand in the high N bits and select at offset N-1-k, which is the bitwise complement of k. The kind of fill placed in the other N-1 bits decides whether the result is a logical, arithmetic or rotate result.

A parameter chooses between a purely combinational result and one captured in an output register.

Top module: `shift_funnel`

## Requirements
- R1: With `kindSel` = 2'b00 and `dirLeft` = 0, the result is the operand moved toward bit 0 by `amountIn` places, with zeros entering at the top (for example, 1011 moved by one gives 0101).
- R2: With `kindSel` = 2'b01 and `dirLeft` = 0, the vacated top bits are copies of operand bit N-1 (for example, 1011 moved by one gives 1101).
- R3: With `kindSel` = 2'b10 and `dirLeft` = 0, bits leaving at bit 0 re-enter at bit N-1, so the count of ones is preserved (1011 gives 1101).
- R4: With `dirLeft` = 1 and `kindSel` equal to 2'b00 or 2'b01, the operand moves toward bit N-1 and zeros enter at bit 0. The logical and arithmetic kinds give identical results (1011 gives 0110).
- R5: With `kindSel` = 2'b10 and `dirLeft` = 1, bits leaving at bit N-1 re-enter at bit 0 (1011 gives 0111).
- R6: An `amountIn` of 0 returns the operand unchanged for every direction and every kind.
- R7: The code `kindSel` = 2'b11 behaves exactly as the logical kind 2'b00 in both directions.
- R8: With `REG_OUT` = 1 (the default), `resultOut` shows the result for the inputs present at a rising clock edge from that edge on, and holds it until the next edge. While `rstN` is low, `resultOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| operandIn | input | W | Value to be shifted or rotated |
| amountIn | input | $clog2(W) | Shift distance k, 0 to W-1 |
| dirLeft | input | 1 | 1 = toward the MSB, 0 = toward the LSB |
| kindSel | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| resultOut | output | W | Shifted or rotated value |

## Verification
On every clock, the assertions check properties that hold independently of the exact bit pattern:
- identity when the amount is zero;
- preservation of the ones count under rotation;
- sign copying into the top bit for arithmetic right shifts;
- a cleared top bit for nonzero logical right shifts;
- a cleared bottom bit for nonzero left shifts.

The exact placement of every bit, the equivalence of the 2'b11 code with the logical kind, the output-register timing and the reset value can only be shown by the bench. It compares each mode, for a sweep of all amounts over several operand patterns, against a behavioural reference written bit by bit.

// File: rtl/shift_funnel_pkg.sv
package shift_funnel_pkg;

  typedef enum logic [1:0] {
    KIND_LOGIC  = 2'b00,
    KIND_ARITH  = 2'b01,
    KIND_ROTATE = 2'b10,
    KIND_SPARE  = 2'b11
  } shift_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic placeHigh;  // operand in the upper N bits (left operation)
    logic fillSign;   // fill the upper N-1 bits with the sign bit
    logic fillWrap;   // fill with the operand's own bits (rotate)
  } shift_ctl_t;

endpackage

// File: rtl/shift_funnel_ctrl.sv
module shift_funnel_ctrl
  import shift_funnel_pkg::*;
#(
  parameter int W = 32,
  localparam int KW = $clog2(W)
) (
  input  logic [KW-1:0] amountIn,
  input  logic          dirLeft,
  input  logic [1:0]    kindSel,
  output shift_ctl_t    ctlOut,
  output logic [KW-1:0] offsetOut
);

  shift_kind_e kind;

  always_comb begin
    kind = shift_kind_e'(kindSel);
    ctlOut.placeHigh = dirLeft;
    ctlOut.fillWrap  = (kind == KIND_ROTATE);
    // sign fill only on right operations; a left arithmetic shift is logical
    ctlOut.fillSign  = (kind == KIND_ARITH) && !dirLeft;
    // a left move by k is a window at N-1-k; W is a power of two, so that is ~k
    offsetOut = dirLeft ? ~amountIn : amountIn;
  end

endmodule

// File: rtl/shift_funnel_source.sv
module shift_funnel_source
  import shift_funnel_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = 2*W - 1
) (
  input  logic [W-1:0]  operandIn,
  input  shift_ctl_t    ctlIn,
  output logic [SW-1:0] funnelOut
);

  logic [W-2:0] lowFill;
  logic [W-2:0] highFill;

  always_comb begin
    lowFill  = ctlIn.fillWrap ? operandIn[W-1:1] : '0;
    if (ctlIn.fillWrap)      highFill = operandIn[W-2:0];
    else if (ctlIn.fillSign) highFill = {(W-1){operandIn[W-1]}};
    else                     highFill = '0;
    if (ctlIn.placeHigh) funnelOut = {operandIn, lowFill};
    else                 funnelOut = {highFill, operandIn};
  end

endmodule

// File: rtl/shift_funnel_window.sv
module shift_funnel_window #(
  parameter int W = 32,
  localparam int KW = $clog2(W),
  localparam int SW = 2*W - 1
) (
  input  logic [SW-1:0] funnelIn,
  input  logic [KW-1:0] offsetIn,
  output logic [W-1:0]  windowOut
);

  // Stage s moves by 2^s and drops 2^s bits; total drop is W-1
  for (genvar s = 0; s < KW; s++) begin : gStage
    localparam int STEP = 1 << s;
    localparam int IW   = SW - STEP + 1;
    localparam int OW   = IW - STEP;
    logic [IW-1:0] inBus;
    logic [OW-1:0] outBus;
    if (s == 0) begin : gFirst
      assign inBus = funnelIn;
    end else begin : gNext
      assign inBus = gStage[s-1].outBus;
    end
    assign outBus = offsetIn[s] ? inBus[IW-1:STEP] : inBus[OW-1:0];
  end

  assign windowOut = gStage[KW-1].outBus;

endmodule

// File: rtl/shift_funnel.sv
module shift_funnel
  import shift_funnel_pkg::*;
#(
  parameter int W = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int KW = $clog2(W),
  localparam int SW = 2*W - 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  operandIn,
  input  logic [KW-1:0] amountIn,
  input  logic          dirLeft,
  input  logic [1:0]    kindSel,
  output logic [W-1:0]  resultOut
);

  shift_ctl_t    ctl;
  logic [KW-1:0] offset;
  logic [SW-1:0] funnelWord;
  logic [W-1:0]  windowVal;

  shift_funnel_ctrl #(.W(W)) uCtrl (
    .amountIn (amountIn),
    .dirLeft  (dirLeft),
    .kindSel  (kindSel),
    .ctlOut   (ctl),
    .offsetOut(offset)
  );

  shift_funnel_source #(.W(W)) uSrc (
    .operandIn(operandIn),
    .ctlIn    (ctl),
    .funnelOut(funnelWord)
  );

  shift_funnel_window #(.W(W)) uWin (
    .funnelIn (funnelWord),
    .offsetIn (offset),
    .windowOut(windowVal)
  );

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resultOut <= '0;
      else       resultOut <= windowVal;
    end
  end else begin : gComb
    assign resultOut = windowVal;
  end

endmodule

// File: rtl/shift_funnel_checker.sv
module shift_funnel_checker #(
  parameter int W = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int KW = $clog2(W)
) (
  input logic          clk,
  input logic          rstN,
  input logic [W-1:0]  operandIn,
  input logic [KW-1:0] amountIn,
  input logic          dirLeft,
  input logic [1:0]    kindSel,
  input logic [W-1:0]  resultOut
);

  logic [W-1:0]  refOp;
  logic [KW-1:0] refAmt;
  logic          refLeft;
  logic [1:0]    refKind;
  logic          refValid;

  if (REG_OUT) begin : gLag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refOp <= '0; refAmt <= '0; refLeft <= 1'b0; refKind <= 2'b00; refValid <= 1'b0;
      end else begin
        refOp <= operandIn; refAmt <= amountIn; refLeft <= dirLeft;
        refKind <= kindSel; refValid <= 1'b1;
      end
    end
  end else begin : gNow
    assign refOp = operandIn;
    assign refAmt = amountIn;
    assign refLeft = dirLeft;
    assign refKind = kindSel;
    assign refValid = 1'b1;
  end

  AST_ZERO_AMOUNT_IDENTITY: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refAmt == '0) |-> resultOut == refOp); // R6

  AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind == 2'b10) |-> $countones(resultOut) == $countones(refOp)); // R3

  AST_ARITH_SIGN_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind == 2'b01 && !refLeft) |-> resultOut[W-1] == refOp[W-1]); // R2

  AST_LOGIC_RIGHT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind[1] == refKind[0] && !refLeft && refAmt != '0) |-> !resultOut[W-1]); // R1

  AST_LEFT_BOTTOM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind != 2'b10 && refLeft && refAmt != '0) |-> !resultOut[0]); // R4

endmodule

bind shift_funnel shift_funnel_checker #(.W(W), .REG_OUT(REG_OUT)) uChk (.*);

// File: tb/tb_shift_funnel.sv
`timescale 1ns/1ps
module tb_shift_funnel;

  localparam int W  = 32;
  localparam int KW = $clog2(W);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  operandIn = '0;
  logic [KW-1:0] amountIn = '0;
  logic          dirLeft = 1'b0;
  logic [1:0]    kindSel = 2'b00;
  logic [W-1:0]  resultOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;  // 125 MHz

  shift_funnel #(.W(W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .operandIn(operandIn), .amountIn(amountIn),
    .dirLeft(dirLeft), .kindSel(kindSel), .resultOut(resultOut)
  );

  function automatic logic [W-1:0] refShift(input logic [W-1:0] a, input int k,
                                            input bit left, input logic [1:0] kind);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) begin
      int src;
      if (left) begin
        src = j - k;
        if (src >= 0) r[j] = a[src];
        else          r[j] = (kind == 2'b10) ? a[src + W] : 1'b0;
      end else begin
        src = j + k;
        if (src < W)              r[j] = a[src];
        else if (kind == 2'b10)   r[j] = a[src - W];
        else if (kind == 2'b01)   r[j] = a[W-1];
        else                      r[j] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic string reqTag(input int k, input bit left, input logic [1:0] kind);
    if (k == 0)          return "R6";
    if (kind == 2'b11)   return "R7";
    if (kind == 2'b10)   return left ? "R5" : "R3";
    if (left)            return "R4";
    return (kind == 2'b01) ? "R2" : "R1";
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  logic [W-1:0] lastExp = '0;

  // Drive at negedge, capture at posedge, check at the following negedge
  task automatic runOne(input logic [W-1:0] a, input int k, input bit left,
                        input logic [1:0] kind);
    logic [W-1:0] exp;
    exp = refShift(a, k, left, kind);
    operandIn = a; amountIn = KW'(k); dirLeft = left; kindSel = kind;
    #1;
    check("R8 hold before edge", resultOut, lastExp);
    @(posedge clk);
    @(negedge clk);
    check(reqTag(k, left, kind), resultOut, exp);
    lastExp = exp;
  endtask

  initial begin
    logic [W-1:0] ops [6];
    logic [W-1:0] lfsr;
    ops[0] = 32'hB000_0001;
    ops[1] = 32'h0000_000B;
    ops[2] = 32'h7FFF_FFFF;
    ops[3] = 32'h8000_0000;
    ops[4] = 32'hDEAD_BEEF;
    ops[5] = 32'h1234_5678;
    lfsr = 32'hACE1_2468;

    operandIn = 32'hFFFF_FFFF; amountIn = 5'd3;
    repeat (3) @(negedge clk);
    check("R8 reset value", resultOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    lastExp = refShift(32'hFFFF_FFFF, 3, 1'b0, 2'b00);
    check("R8 first capture", resultOut, lastExp);

    for (int o = 0; o < 7; o++) begin
      logic [W-1:0] a;
      a = (o < 6) ? ops[o] : lfsr;
      for (int kind = 0; kind < 4; kind++)
        for (int d = 0; d < 2; d++)
          for (int k = 0; k < W; k++)
            runOne(a, k, d[0], kind[1:0]);
    end

    // R7: spare code matches logical explicitly
    runOne(32'hC3A5_5A3C, 9, 1'b0, 2'b11);
    check("R7 spare equals logical right", resultOut, refShift(32'hC3A5_5A3C, 9, 1'b0, 2'b00));
    runOne(32'hC3A5_5A3C, 9, 1'b1, 2'b11);
    check("R7 spare equals logical left", resultOut, refShift(32'hC3A5_5A3C, 9, 1'b1, 2'b00));
    // R4: left arithmetic equals left logical
    runOne(32'hF00F_1001, 13, 1'b1, 2'b01);
    check("R4 left arith equals left logical", resultOut, refShift(32'hF00F_1001, 13, 1'b1, 2'b00));

    // R8: reset clears output mid-run
    #1 rstN = 1'b0;
    #1;
    check("R8 async reset clears", resultOut, '0);
    @(negedge clk);
    rstN = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 8);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule